// File: doc/BRIEF.md
# Beat Tempo and Cue LED Generator

This block supplies the timing backbone of a reaction game. A counter enable, derived from the system clock by a parameterized divider, marks a beat every quarter of a second. Beats are grouped into four-beat rounds by a 2-bit beat index. The block drives a tempo LED that blinks once per beat, and a row of cue LEDs that shows the player which control to use.

A game controller supplies a 3-bit target value and an enable. While the enable is high, the cue LED chosen by the target lights for the first two beats of every round and goes dark for the last two. The controller receives a single-cycle beat tick, the current beat index, and a single-cycle end-of-round pulse, so that it can sequence its own decisions. Everything runs in the system clock domain. No derived clocks are generated.

Top module: `beat_cue_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the divider and the beat index. In the first cycle after release and during reset, `beat_idx` is 0, `beat_wave` is 1 and `beat_tick` is 0.
- R2: The beat period is P = CLK_HZ / BEATS_PER_SEC cycles, which is one quarter second by default. `beat_tick` is high for exactly one cycle per period, in the P-th cycle after reset release and in every P-th cycle after that.
- R3: Within each beat, `beat_wave` is high for the first floor(P/2) cycles and low for the rest. `tempo_led` always equals `beat_wave`.
- R4: `beat_idx` advances by one in the cycle after each `beat_tick`, and wraps from 3 to 0. At all other times it holds its value.
- R5: `round_end` is high only in the cycle where `beat_tick` is high and `beat_idx` is 3. That cycle is the last cycle of each four-beat round.
- R6: With `en` high and `target` equal to k, for k in 0, 1 or 2, only `cue_led[k]` is lit, and only while `beat_idx` is 0 or 1. All cue LEDs are off while `beat_idx` is 2 or 3. A change of `target` acts in the same cycle.
- R7: A `target` value of 3 to 7 lights no cue LED.
- R8: While `en` is low, all cue LEDs are off. The tick, the wave, the index and the round pulse do not depend on `en` or `target`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables the cue LEDs |
| target | input | TGT_W (3) | Binary index of the cue LED to light |
| beat_tick | output | 1 | One-cycle pulse in the last cycle of each beat |
| beat_wave | output | 1 | Beat square wave, high for the first half of the beat |
| tempo_led | output | 1 | Tempo indicator LED |
| beat_idx | output | 2 | Position of the current beat within the round |
| round_end | output | 1 | One-cycle pulse in the last cycle of each round |
| cue_led | output | NUM_CUES (3) | Cue indicator LEDs |

## Verification
The bench builds the block with CLK_HZ = 36 and BEATS_PER_SEC = 4. This gives a nine-cycle beat and a 36-cycle round, so many whole rounds, index wraps and round pulses fit into a few hundred cycles. The odd period makes the high and low halves of the wave unequal (4 and 5 cycles), which exposes any off-by-one error in the half-period compare. A reset in the middle of a beat, all eight target codes, and toggling of the enable are each compared against the reference model in every cycle.

// File: rtl/beat_cue_gen.sv
module beat_cue_gen #(
  parameter int CLK_HZ        = 50_000_000,
  parameter int BEATS_PER_SEC = 4,
  parameter int NUM_CUES      = 3,
  parameter int TGT_W         = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [TGT_W-1:0]    target,
  output logic                beat_tick,
  output logic                beat_wave,
  output logic                tempo_led,
  output logic [1:0]          beat_idx,
  output logic                round_end,
  output logic [NUM_CUES-1:0] cue_led
);

  localparam int PERIOD = CLK_HZ / BEATS_PER_SEC;
  localparam int HALF   = PERIOD / 2;
  localparam int DIV_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [DIV_W-1:0] div_q;
  logic [1:0]       idx_q;
  logic             cue_window;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      idx_q <= '0;
    end else if (beat_tick) begin
      div_q <= '0;
      idx_q <= idx_q + 2'd1;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  assign beat_tick  = (div_q == DIV_W'(PERIOD - 1));
  assign beat_wave  = (div_q < DIV_W'(HALF));
  assign tempo_led  = beat_wave;
  assign beat_idx   = idx_q;
  assign round_end  = beat_tick & (idx_q == 2'd3);
  assign cue_window = en & ~idx_q[1];

  for (genvar g = 0; g < NUM_CUES; g++) begin : g_cue
    assign cue_led[g] = cue_window & (target == TGT_W'(g));
  end

  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    beat_tick |=> !beat_tick);

  p_wave_starts_high_r3: assert property (@(posedge clk) disable iff (rst)
    beat_tick |=> beat_wave);

  p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
    beat_tick |=> (beat_idx == $past(beat_idx) + 2'd1));

  p_idx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !beat_tick |=> $stable(beat_idx));

  p_round_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    round_end |=> (beat_idx == 2'd0));

  p_cue_single_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cue_led));

endmodule

// File: tb/beat_cue_gen_tb.sv
module beat_cue_gen_tb;
  localparam int CLK_HZ = 36;
  localparam int BPS    = 4;
  localparam int P      = CLK_HZ / BPS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [2:0] target = 3'd0;
  logic beat_tick, beat_wave, tempo_led, round_end;
  logic [1:0] beat_idx;
  logic [2:0] cue_led;

  int total = 0;
  int bad = 0;
  int n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  beat_cue_gen #(.CLK_HZ(CLK_HZ), .BEATS_PER_SEC(BPS), .NUM_CUES(3), .TGT_W(3)) u_dut (
    .clk(clk), .rst(rst), .en(en), .target(target),
    .beat_tick(beat_tick), .beat_wave(beat_wave), .tempo_led(tempo_led),
    .beat_idx(beat_idx), .round_end(round_end), .cue_led(cue_led));

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s at n=%0d: actual=%0d expected=%0d", req, what, n, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic e, input logic [2:0] t);
    int d, i, ecue;
    rst = r; en = e; target = t;
    #1;
    d = n % P;
    i = (n / P) % 4;
    ecue = (e && t < 3 && i < 2) ? (1 << t) : 0;
    chk(n == 0 ? "R1" : "R2", "beat_tick", int'(beat_tick), int'(d == P - 1));
    chk(n == 0 ? "R1" : "R3", "beat_wave", int'(beat_wave), int'(d < P / 2));
    chk("R3", "tempo_led", int'(tempo_led), int'(d < P / 2));
    chk(n == 0 ? "R1" : "R4", "beat_idx", int'(beat_idx), i);
    chk("R5", "round_end", int'(round_end), int'(d == P - 1 && i == 3));
    if (!e)        chk("R8", "cue_led", int'(cue_led), ecue);
    else if (t > 2) chk("R7", "cue_led", int'(cue_led), ecue);
    else            chk("R6", "cue_led", int'(cue_led), ecue);
    @(posedge clk);
    n = r ? 0 : n + 1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 3'd0);
    for (int t = 0; t < 8; t++)
      for (int k = 0; k < 4 * P; k++) cyc(1'b0, 1'b1, 3'(t));
    for (int k = 0; k < 5 * P; k++) cyc(1'b0, 1'b0, 3'd1);
    for (int k = 0; k < 13; k++) cyc(1'b0, 1'b1, 3'd2);
    for (int k = 0; k < 2; k++) cyc(1'b1, 1'b1, 3'd2);
    for (int k = 0; k < 6 * P; k++) cyc(1'b0, (k % 5) < 3, 3'(k % 4));
    for (int k = 0; k < 3 * P; k++) cyc(1'b0, 1'b1, 3'((k / 3) % 3));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule